// File: doc/BRIEF.md
# SPI Flash Command Frame Validator

This block watches the single-bit serial input of a flash device. While chip select is low, it samples the serial data line on each rising edge of the serial clock, most significant bit first. The first eight bits form the command code. Every later group of eight bits is passed on as an address or data byte, each with a one-cycle valid strobe. All serial pins are brought into the system clock domain through two-stage synchronisers. Edges are found by comparing consecutive synchronised samples.

Each command code is sorted into one of two classes: modifying commands, which form a parameterised list, and non-modifying commands. When chip select rises, a modifying command gets a verdict. It is committed if the number of serial clocks in the frame is an exact multiple of eight. Otherwise it is rejected, so a partial trailing byte cancels the whole command and leaves no lasting effect. A non-modifying command may end after any bit and produces no verdict. A frame that ends before the command code is complete also produces no verdict.

Top module: `spi_cmd_gate`

## Requirements
- R1: After reset, `cmd_valid`, `data_valid`, `commit` and `reject` are 0, and `cmd_code` and `data_byte` are 0.
- R2: Bits on `spi_si` are taken on rising `spi_sclk` edges while `spi_cs_n` is low, MSB first. After the 8th bit, `cmd_valid` pulses for one cycle and `cmd_code` holds the assembled code.
- R3: After the command code, each further complete group of 8 bits produces a one-cycle `data_valid` pulse, with the assembled byte (MSB first) on `data_byte`. `data_valid` and `cmd_valid` are never high together.
- R4: A command whose code is in the modifying list (default 0x02, 0x20, 0xD8, 0xC7, 0x01, 0x06, 0x04, 0xB9) and whose frame has a clock count that is a multiple of eight gives exactly one `commit` pulse after `spi_cs_n` rises, and no `reject`.
- R5: A modifying command whose frame has a clock count that is not a multiple of eight gives exactly one `reject` pulse and no `commit`.
- R6: A command code outside the modifying list gives neither `commit` nor `reject`, whatever the clock count.
- R7: A frame with fewer than 8 clocks gives no `cmd_valid`, `commit` or `reject`. The bit counter and the partial byte are cleared while `spi_cs_n` is high, so the next frame starts clean.
- R8: `commit` and `reject` are single-cycle pulses, are never high together, and only follow a cycle in which the synchronised chip select was high.
- R9: `cmd_is_write` is 1 from the cycle after the command code is complete until chip select is seen high, when the code is in the modifying list. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_si | input | 1 | Serial data in |
| cmd_code | output | 8 | Last assembled command code |
| cmd_valid | output | 1 | Pulse: command code complete |
| cmd_is_write | output | 1 | Current command is in the modifying class |
| data_byte | output | 8 | Byte assembled after the command code |
| data_valid | output | 1 | Pulse: `data_byte` complete |
| commit | output | 1 | Pulse: modifying command accepted |
| reject | output | 1 | Pulse: modifying command cancelled |

## Verification
The assertions check on every cycle that the verdict pulses are exclusive and one cycle long, that they come only after chip select is seen high, that byte and code strobes never coincide, and that the frame state is cleared while deselected. Only the bench scenarios can show that the verdict matches the clock count and the opcode class. The bench sweeps every listed modifying code and several non-modifying codes over frame lengths from 0 to 25 clocks. It also checks that each data byte is assembled in the right bit order.

// File: rtl/spi_cmd_gate.sv
module spi_cmd_gate #(
  parameter int NUM_WR = 8,
  parameter logic [8*NUM_WR-1:0] WR_OPS = 64'h02_20_D8_C7_01_06_04_B9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_si,
  output logic [7:0] cmd_code,
  output logic       cmd_valid,
  output logic       cmd_is_write,
  output logic [7:0] data_byte,
  output logic       data_valid,
  output logic       commit,
  output logic       reject
);

  logic [2:0] sclk_q, cs_q, si_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       have_op;
  logic       wr_match;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire cs_hi     = cs_q[1];
  wire cs_rise   = cs_q[1] & ~cs_q[2];
  wire [7:0] full = {shreg, si_q[1]};
  wire last_bit  = ~cs_hi & sclk_rise & (bit_cnt == 3'd7);

  always_comb begin
    wr_match = 1'b0;
    for (int i = 0; i < NUM_WR; i++)
      if (WR_OPS[8*i +: 8] == full) wr_match = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      si_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      si_q   <= {si_q[1:0], spi_si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt      <= '0;
      shreg        <= '0;
      have_op      <= 1'b0;
      cmd_is_write <= 1'b0;
      cmd_code     <= '0;
    end else if (cs_hi) begin
      bit_cnt      <= '0;
      shreg        <= '0;
      have_op      <= 1'b0;
      cmd_is_write <= 1'b0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      shreg   <= full[6:0];
      if (bit_cnt == 3'd7 && !have_op) begin
        have_op      <= 1'b1;
        cmd_code     <= full;
        cmd_is_write <= wr_match;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      data_byte  <= '0;
      commit     <= 1'b0;
      reject     <= 1'b0;
    end else begin
      cmd_valid  <= last_bit & ~have_op;
      data_valid <= last_bit & have_op;
      if (last_bit && have_op) data_byte <= full;
      commit     <= cs_rise & have_op & cmd_is_write & (bit_cnt == 3'd0);
      reject     <= cs_rise & have_op & cmd_is_write & (bit_cnt != 3'd0);
    end
  end

  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && reject)); // R8
  AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || reject) |=> !(commit || reject)); // R8
  AST_OUTCOME_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || reject) |-> $past(cs_hi)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && data_valid)); // R3
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (bit_cnt == 3'd0 && !have_op && !cmd_is_write)); // R7
  AST_CMD_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> have_op); // R3

endmodule

// File: tb/spi_cmd_gate_tb.sv
module spi_cmd_gate_tb;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, csn = 1, si = 0;
  logic [7:0] cmd_code, data_byte;
  logic cmd_valid, cmd_is_write, data_valid, commit, reject;

  always #2.5 clk = ~clk;

  spi_cmd_gate u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(csn), .spi_si(si),
    .cmd_code(cmd_code), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
    .data_byte(data_byte), .data_valid(data_valid), .commit(commit), .reject(reject));

  int errors = 0, checks = 0;
  int n_commit = 0, n_reject = 0, n_cmd = 0, n_byte = 0;
  logic [7:0] last_code;
  logic [7:0] bytes [0:4095];
  logic saw_write;

  always @(negedge clk) begin
    if (commit) n_commit++;
    if (reject) n_reject++;
    if (cmd_valid) begin n_cmd++; last_code = cmd_code; end
    if (data_valid) begin bytes[n_byte % 4096] = data_byte; n_byte++; end
    if (cmd_is_write) saw_write = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  localparam logic [7:0] WR [8] = '{8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'h06, 8'h04, 8'hB9};
  localparam logic [7:0] RD [5] = '{8'h03, 8'h0B, 8'h05, 8'hAB, 8'h9F};

  function automatic logic [7:0] frame_byte(input logic [7:0] op, input int k);
    return (k == 0) ? op : ((op + 8'(29 * k)) ^ 8'h5A);
  endfunction

  task automatic frame(input logic [7:0] op, input bit is_wr, input int nbits);
    int c0, r0, m0, b0, nb;
    c0 = n_commit; r0 = n_reject; m0 = n_cmd; b0 = n_byte;
    saw_write = 1'b0;
    @(posedge clk); csn <= 0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      si <= frame_byte(op, i / 8)[7 - (i % 8)];
      repeat (4) @(posedge clk); sclk <= 1;
      repeat (4) @(posedge clk); sclk <= 0;
    end
    repeat (4) @(posedge clk); csn <= 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    if (nbits < 8) begin
      check("R7 cmd_valid count", n_cmd - m0, 0);
      check("R7 commit count", n_commit - c0, 0);
      check("R7 reject count", n_reject - r0, 0);
    end else begin
      check("R2 cmd_valid count", n_cmd - m0, 1);
      check("R2 cmd_code", last_code, op);
      check("R9 cmd_is_write", saw_write, is_wr);
      if (!is_wr) begin
        check("R6 commit count", n_commit - c0, 0);
        check("R6 reject count", n_reject - r0, 0);
      end else if (nbits % 8 == 0) begin
        check("R4 commit count", n_commit - c0, 1);
        check("R4 reject count", n_reject - r0, 0);
      end else begin
        check("R5 reject count", n_reject - r0, 1);
        check("R5 commit count", n_commit - c0, 0);
      end
    end
    nb = (nbits < 8) ? 0 : (nbits - 8) / 8;
    check("R3 data_valid count", n_byte - b0, nb);
    if (n_byte - b0 == nb)
      for (int k = 0; k < nb; k++)
        check("R3 data_byte", bytes[(b0 + k) % 4096], frame_byte(op, k + 1));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 data_valid", data_valid, 0);
    check("R1 commit", commit, 0);
    check("R1 reject", reject, 0);
    check("R1 cmd_code", cmd_code, 0);
    check("R1 data_byte", data_byte, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    for (int n = 0; n <= 25; n++) begin
      for (int w = 0; w < 8; w++) frame(WR[w], 1'b1, n);
      for (int r = 0; r < 5; r++) frame(RD[r], 1'b0, n);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule